// File: doc/BRIEF.md
# Supervisor Trap Entry Unit

This unit holds the supervisor-level interrupt control state of a RISC-V-style hart and performs hardware trap entry and trap return. The state is a global interrupt enable, the saved previous privilege, a per-source enable mask, a pending view of the raw interrupt lines, a cause register, an exception pc and a trap vector base. The unit takes the current pc and privilege from the core, along with three interrupt lines (external, timer, software), a synchronous exception request with its code, and a return strobe.

A trap is decided combinationally. In the same cycle the unit drives a redirect strobe, the target pc and the new privilege. At the following clock edge it commits every state change of the entry or return sequence at once. The core reads and writes the registers through a small select-addressed port. Only direct trap mode is supported, so the vector base is always 4-byte aligned.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, every readable register (select 0,1,3,4,5) reads zero and no redirect is driven.
- R2: Select 2 reads the raw lines as software at bit 1, timer at bit 5 and external at bit 9, whatever the enables are. Writes to select 2 have no effect.
- R3: An interrupt is taken only when its line, its enable bit (select 1: bit 1 software, bit 5 timer, bit 9 external) and the global enable (select 0, bit 1) are all set. Otherwise no redirect occurs and no register changes.
- R4: Among pending and enabled interrupts, external is taken before software, and software before timer. An exception request is taken before any interrupt and is taken even when the global enable is clear.
- R5: A taken interrupt writes the cause register with bit XLEN-1 set and code 1 (software), 5 (timer) or 9 (external) in the low bits. An exception writes its zero-extended code with bit XLEN-1 clear.
- R6: In the cycle a trap is taken, redir_valid_o is 1, redir_pc_o equals the vector base and priv_o is 1 (supervisor).
- R7: After a trap, the exception pc holds the pc of the trap cycle and status bit 8 holds the prior privilege (1 = supervisor, 0 = user). The global enable is 0.
- R8: In the cycle sret_i is high, the unit redirects to the saved exception pc with priv_o equal to status bit 8. After that cycle, status bit 8 is 0 and the global enable is 1.
- R9: A register write in a cycle that takes a trap or a return is ignored. A trap in the same cycle as sret_i wins, and the return is ignored.
- R10: Only status bits 1 and 8 and enable bits 1, 5 and 9 are stored, and every other bit of those registers reads 0. The vector base reads back with bits 1:0 cleared. Selects 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | Pc of the current instruction |
| priv_i | input | 1 | Current privilege, 1 supervisor, 0 user |
| irq_ext_i | input | 1 | External interrupt line |
| irq_tmr_i | input | 1 | Timer interrupt line |
| irq_sw_i | input | 1 | Software interrupt line |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | CODE_W | Exception cause code |
| sret_i | input | 1 | Trap return strobe |
| csr_we_i | input | 1 | Register write enable |
| csr_sel_i | input | 3 | Register select: 0 status, 1 enable, 2 pending, 3 cause, 4 exception pc, 5 vector base |
| csr_wdata_i | input | XLEN | Register write data |
| csr_rdata_o | output | XLEN | Register read data, combinational |
| redir_valid_o | output | 1 | Redirect strobe |
| redir_pc_o | output | XLEN | Redirect target |
| priv_o | output | 1 | Privilege after this cycle |

## Verification
The trap decision is tried with a table of enable and line combinations. These include each source alone, all sources together, software with timer, and lines whose enable bit is clear. Together they separate the priority order from plain masking. Cases with the global enable clear, with and without an exception, show that exceptions bypass the mask while interrupts do not. Directed cases return with both saved privileges, and they collide a write, a return and a trap in one cycle to show which action wins.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int XLEN   = 64,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              priv_i,
  input  logic              irq_ext_i,
  input  logic              irq_tmr_i,
  input  logic              irq_sw_i,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              sret_i,
  input  logic              csr_we_i,
  input  logic [2:0]        csr_sel_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              redir_valid_o,
  output logic [XLEN-1:0]   redir_pc_o,
  output logic              priv_o
);
  localparam int BIT_SW  = 1;
  localparam int BIT_TMR = 5;
  localparam int BIT_EXT = 9;
  localparam int BIT_GIE = 1;
  localparam int BIT_PRV = 8;
  localparam logic [2:0] SEL_ST = 3'd0, SEL_IE = 3'd1, SEL_IP = 3'd2,
                         SEL_CA = 3'd3, SEL_EPC = 3'd4, SEL_TV = 3'd5;

  logic            sie_q, spp_q;
  logic [2:0]      ie_q;
  logic [XLEN-1:0] cause_q, epc_q, tvec_q;
  logic [3:0]      irq_code;

  wire [2:0] lines     = {irq_ext_i, irq_tmr_i, irq_sw_i};
  wire [2:0] pend      = lines & ie_q;
  wire       irq_take  = sie_q && (|pend);
  wire       trap_take = exc_req_i || irq_take;
  wire       ret_take  = sret_i && !trap_take;
  wire       wr_ok     = csr_we_i && !trap_take && !ret_take;

  always_comb begin
    if (pend[2])      irq_code = 4'd9;
    else if (pend[0]) irq_code = 4'd1;
    else              irq_code = 4'd5;
  end

  wire [XLEN-1:0] trap_cause = exc_req_i
    ? {{(XLEN-CODE_W){1'b0}}, exc_code_i}
    : {1'b1, {(XLEN-5){1'b0}}, irq_code};

  assign redir_valid_o = trap_take || ret_take;
  assign redir_pc_o    = trap_take ? tvec_q : epc_q;
  assign priv_o        = trap_take ? 1'b1 : (ret_take ? spp_q : priv_i);

  always_comb begin
    csr_rdata_o = '0;
    case (csr_sel_i)
      SEL_ST: begin
        csr_rdata_o[BIT_GIE] = sie_q;
        csr_rdata_o[BIT_PRV] = spp_q;
      end
      SEL_IE: begin
        csr_rdata_o[BIT_SW]  = ie_q[0];
        csr_rdata_o[BIT_TMR] = ie_q[1];
        csr_rdata_o[BIT_EXT] = ie_q[2];
      end
      SEL_IP: begin
        csr_rdata_o[BIT_SW]  = irq_sw_i;
        csr_rdata_o[BIT_TMR] = irq_tmr_i;
        csr_rdata_o[BIT_EXT] = irq_ext_i;
      end
      SEL_CA:  csr_rdata_o = cause_q;
      SEL_EPC: csr_rdata_o = epc_q;
      SEL_TV:  csr_rdata_o = tvec_q;
      default: csr_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sie_q   <= 1'b0;
      spp_q   <= 1'b0;
      ie_q    <= '0;
      cause_q <= '0;
      epc_q   <= '0;
      tvec_q  <= '0;
    end else if (trap_take) begin
      sie_q   <= 1'b0;
      spp_q   <= priv_i;
      cause_q <= trap_cause;
      epc_q   <= pc_i;
    end else if (ret_take) begin
      sie_q   <= 1'b1;
      spp_q   <= 1'b0;
    end else if (wr_ok) begin
      case (csr_sel_i)
        SEL_ST: begin
          sie_q <= csr_wdata_i[BIT_GIE];
          spp_q <= csr_wdata_i[BIT_PRV];
        end
        SEL_IE:  ie_q    <= {csr_wdata_i[BIT_EXT], csr_wdata_i[BIT_TMR], csr_wdata_i[BIT_SW]};
        SEL_CA:  cause_q <= csr_wdata_i;
        SEL_EPC: epc_q   <= csr_wdata_i;
        SEL_TV:  tvec_q  <= {csr_wdata_i[XLEN-1:2], 2'b00};
        default: ;
      endcase
    end
  end
endmodule

module trap_entry_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] pc_i,
  input logic            priv_i,
  input logic            exc_req_i,
  input logic            sret_i,
  input logic            redir_valid_o,
  input logic            priv_o,
  input logic            sie_q,
  input logic            spp_q,
  input logic [XLEN-1:0] epc_q,
  input logic            trap_take
);
  AST_MASKED_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_i && !sret_i && !sie_q) |-> !redir_valid_o); // R3
  AST_EXC_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i |-> (redir_valid_o && priv_o)); // R4
  AST_TRAP_SUPERVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> priv_o); // R6
  AST_TRAP_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> !sie_q); // R7
  AST_TRAP_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> (epc_q == $past(pc_i) && spp_q == $past(priv_i))); // R7
  AST_RET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (sret_i && !trap_take) |=> (sie_q && !spp_q)); // R8
endmodule

bind trap_entry_unit trap_entry_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .priv_i(priv_i),
  .exc_req_i(exc_req_i), .sret_i(sret_i), .redir_valid_o(redir_valid_o),
  .priv_o(priv_o), .sie_q(sie_q), .spp_q(spp_q), .epc_q(epc_q),
  .trap_take(trap_take)
);

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb_top;
  localparam int XLEN = 64;
  localparam int CODE_W = 5;
  localparam logic [XLEN-1:0] TVEC = 64'h8000_0100;
  localparam logic [XLEN-1:0] IBIT = 64'h8000_0000_0000_0000;

  logic clk = 0, rst_n = 0;
  logic [XLEN-1:0] pc_i = '0, csr_wdata_i = '0;
  logic priv_i = 0, irq_ext_i = 0, irq_tmr_i = 0, irq_sw_i = 0, exc_req_i = 0, sret_i = 0, csr_we_i = 0;
  logic [CODE_W-1:0] exc_code_i = 5'd8;
  logic [2:0] csr_sel_i = '0;
  logic [XLEN-1:0] csr_rdata_o, redir_pc_o;
  logic redir_valid_o, priv_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .CODE_W(CODE_W)) dut_i (.*);

  // [15] global enable, [14:12] enables e/t/s, [11:9] lines e/t/s, [8] exception,
  // [7] expect redirect, [6:3] expected code, [2] expected interrupt flag
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'b1_111_100_0_1_1001_1_00,
    16'b1_111_010_0_1_0101_1_00,
    16'b1_111_001_0_1_0001_1_00,
    16'b1_111_111_0_1_1001_1_00,
    16'b1_111_011_0_1_0001_1_00,
    16'b0_111_111_0_0_0000_0_00,
    16'b1_000_111_0_0_0000_0_00,
    16'b1_101_010_0_0_0000_0_00,
    16'b0_000_000_1_1_1000_0_00,
    16'b1_111_111_1_1_1000_0_00,
    16'b1_010_110_0_1_0101_1_00,
    16'b1_001_000_0_0_0000_0_00
  };

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we_i = 1; csr_sel_i = sel; csr_wdata_i = d;
    @(negedge clk);
    csr_we_i = 0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [XLEN-1:0] d);
    csr_sel_i = sel;
    #0.5;
    d = csr_rdata_o;
  endtask

  function automatic logic [XLEN-1:0] ie_bits(logic [2:0] m);
    return (XLEN'(m[2]) << 9) | (XLEN'(m[1]) << 5) | (XLEN'(m[0]) << 1);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [XLEN-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 6; s++) begin
      if (s == 2) continue;
      rd(3'(s), r); check("R1 reset read", r, '0);
    end
    check("R1 no redirect", {63'b0, redir_valid_o}, 64'd0);

    // R10 field masks
    wr(3'd0, '1); rd(3'd0, r); check("R10 status mask", r, 64'h102);
    wr(3'd1, '1); rd(3'd1, r); check("R10 enable mask", r, 64'h222);
    wr(3'd5, '1); rd(3'd5, r); check("R10 vector align", r, ~64'h3);
    wr(3'd6, '1); rd(3'd6, r); check("R10 unused select", r, '0);

    // R2 pending view, read-only
    wr(3'd0, '0);
    @(negedge clk); irq_ext_i = 1; irq_tmr_i = 1; irq_sw_i = 1;
    rd(3'd2, r); check("R2 pending all", r, 64'h222);
    irq_ext_i = 0; irq_sw_i = 0;
    rd(3'd2, r); check("R2 pending timer", r, 64'h20);
    irq_tmr_i = 0;
    wr(3'd2, '1); rd(3'd2, r); check("R2 write ignored", r, '0);

    wr(3'd5, TVEC);

    // vector walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      logic [XLEN-1:0] ecause, pcv;
      v = VEC[i];
      pcv = 64'h4000_0000 + XLEN'(i * 4);
      wr(3'd1, ie_bits(v[14:12]));
      wr(3'd0, XLEN'(v[15]) << 1);
      wr(3'd3, '0);
      wr(3'd4, '0);
      @(negedge clk);
      {irq_ext_i, irq_tmr_i, irq_sw_i} = v[11:9];
      exc_req_i = v[8]; pc_i = pcv; priv_i = i[0];
      #0.5;
      check($sformatf("R3/R4 redirect vec %0d", i), {63'b0, redir_valid_o}, {63'b0, v[7]});
      if (v[7]) begin
        check($sformatf("R6 target vec %0d", i), redir_pc_o, TVEC);
        check($sformatf("R6 priv vec %0d", i), {63'b0, priv_o}, 64'd1);
      end
      @(negedge clk);
      {irq_ext_i, irq_tmr_i, irq_sw_i} = 3'b000; exc_req_i = 0;
      ecause = v[7] ? ((v[2] ? IBIT : '0) | XLEN'(v[6:3])) : '0;
      rd(3'd3, r); check($sformatf("R5 cause vec %0d", i), r, ecause);
      rd(3'd0, r);
      check($sformatf("R7 status vec %0d", i), r,
            v[7] ? (XLEN'(i[0]) << 8) : (XLEN'(v[15]) << 1));
      rd(3'd4, r); check($sformatf("R7 saved pc vec %0d", i), r, v[7] ? pcv : '0);
    end
    priv_i = 0;

    // R8 return to supervisor
    wr(3'd0, 64'h100);
    wr(3'd4, 64'h1234_5678);
    @(negedge clk); sret_i = 1; #0.5;
    check("R8 return redirect", {63'b0, redir_valid_o}, 64'd1);
    check("R8 return target", redir_pc_o, 64'h1234_5678);
    check("R8 return priv sup", {63'b0, priv_o}, 64'd1);
    @(negedge clk); sret_i = 0;
    rd(3'd0, r); check("R8 status after return", r, 64'h2);
    // R8 return to user
    @(negedge clk); sret_i = 1; #0.5;
    check("R8 return priv user", {63'b0, priv_o}, 64'd0);
    @(negedge clk); sret_i = 0;

    // R9 write during return ignored
    wr(3'd0, 64'h0);
    @(negedge clk); sret_i = 1; csr_we_i = 1; csr_sel_i = 3'd4; csr_wdata_i = 64'hdead_0000;
    @(negedge clk); sret_i = 0; csr_we_i = 0;
    rd(3'd4, r); check("R9 write during return", r, 64'h1234_5678);
    // R9 trap beats return and write
    wr(3'd0, 64'h0);
    @(negedge clk); exc_req_i = 1; sret_i = 1; pc_i = 64'h7777_0000; priv_i = 1;
    csr_we_i = 1; csr_sel_i = 3'd5; csr_wdata_i = 64'h9999_0000;
    #0.5;
    check("R9 trap over return target", redir_pc_o, TVEC);
    @(negedge clk); exc_req_i = 0; sret_i = 0; csr_we_i = 0; priv_i = 0;
    rd(3'd5, r); check("R9 vector unchanged", r, TVEC);
    rd(3'd0, r); check("R9 return ignored", r, 64'h100);
    rd(3'd4, r); check("R9 pc saved", r, 64'h7777_0000);

    finish_run();
  end
endmodule